// File: doc/BRIEF.md
# Round-Robin Replicated Multicycle Unit

This block runs a multicycle operation whose busy time is longer than the restart period the surrounding pipeline wants. A single instance cannot take a new operand set every R cycles, because it needs its operands held for its T compute cycles. It then has to keep its result steady for the T_NEXT cycles that the consuming stage needs. The block therefore builds C identical copies and hands successive operand sets to them in rotation. Each copy has its own operand register, so it keeps its inputs for the whole computation and keeps its result for the whole hold window.

The copy count is fixed when the block is elaborated. The busy span of one copy is Q = T + T_NEXT. A copy can only be reused after more than Q cycles, so C = ceil((Q + 1) / R), which gives C × R ≥ Q + 1. The computed function is a stand-in: the W-bit sum of two operands, produced after exactly T cycles. An output multiplexer shows the result of whichever copy is in its hold window. Results leave in arrival order.

Top module: `rrmc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears every copy, the rotation pointer and the error flag. After that edge `out_valid` is 0, `out_data` is 0 and `err` is 0.
- R2: Each result equals (in_a + in_b) modulo 2^W for the operand set it belongs to. Carries beyond W bits are dropped.
- R3: An operand set accepted at rising edge k produces `out_valid` = 1 for exactly T_NEXT cycles, from edge k+T up to edge k+T+T_NEXT. `out_data` holds that result unchanged throughout.
- R4: Strobes spaced exactly R cycles apart are all accepted, with no limit on how many follow each other. Their results appear in arrival order and none corrupts another.
- R5: A strobe that comes fewer than R edges after the last accepted strobe is dropped. It produces no result window, and `err` becomes 1 after that edge.
- R6: Once set, `err` stays 1 until a reset.
- R7: A strobe that comes more than R edges after the last accepted strobe is accepted normally and does not set `err`.
- R8: Outside every hold window `out_valid` is 0 and `out_data` is 0. At most one copy owns the output at any time.
- R9: A reset during a computation drops every pending result. No result window appears after the reset.
- R10: The first strobe after reset is accepted whatever the spacing to strobes taken before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe, expected once every R cycles |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | High during the hold window of a result |
| out_data | output | W | Result of the copy that owns the current window, zero otherwise |
| err | output | 1 | Sticky flag: a strobe came too early and was dropped |

## Verification
The hardest case to reach is an early strobe that lands on a cycle where a copy is in the middle of its computation. If that strobe were wrongly accepted, it would overwrite that copy's operand register or shift the rotation. The bench sends an accepted set and, on the very next edge, a second strobe with different operands. It then resumes at the regular spacing from the accepted one. The cycle-exact output model then shows any extra window, missing window or changed sum. A reset issued while two copies are busy, followed at once by a new strobe, covers the abandoned results and the restart of the rotation.

// File: rtl/rrmc_pkg.sv
package rrmc_pkg;

    // number of copies so that one copy is not restarted within its busy span
    function automatic int unsigned rrmc_copies(input int unsigned t,
                                                input int unsigned t_next,
                                                input int unsigned r);
        int unsigned span;
        span = t + t_next + 1;
        return (span + r - 1) / r;
    endfunction

endpackage

// File: rtl/rrmc_copy.sv
module rrmc_copy #(
    parameter int unsigned W      = 16,
    parameter int unsigned T      = 4,
    parameter int unsigned T_NEXT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         hold,
    output logic [W-1:0] res
);
    localparam int unsigned Q  = T + T_NEXT;
    localparam int unsigned CW = $clog2(Q + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  res;
    } copy_state_t;

    copy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = CW'(1);
            st_d.a   = op_a;
            st_d.b   = op_b;
        end else if (st_q.cnt != '0) begin
            if (st_q.cnt == CW'(Q)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        // last compute cycle: the sum becomes the held result
        if (st_q.cnt == CW'(T)) begin
            st_d.res = st_q.a + st_q.b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = (st_q.cnt > CW'(T));
    assign res  = st_q.res;

endmodule

// File: rtl/rrmc_issue.sv
module rrmc_issue #(
    parameter int unsigned C = 3,
    parameter int unsigned R = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic [C-1:0] start,
    output logic         err
);
    localparam int unsigned PW = (C > 1) ? $clog2(C) : 1;
    localparam int unsigned GW = $clog2(R + 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [GW-1:0] gap;
        logic          seen;
        logic          err;
    } issue_state_t;

    issue_state_t st_d, st_q;
    logic         accept;

    assign accept = in_valid && (!st_q.seen || (st_q.gap >= GW'(R)));

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.seen = 1'b1;
            st_d.gap  = GW'(1);
            if (st_q.ptr == PW'(C - 1)) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + PW'(1);
            end
        end else if (st_q.gap < GW'(R)) begin
            st_d.gap = st_q.gap + GW'(1);
        end
        if (in_valid && !accept) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < C; i++) begin : g_start
        assign start[i] = accept && (st_q.ptr == PW'(i));
    end

    assign err = st_q.err;

endmodule

// File: rtl/rrmc_outmux.sv
module rrmc_outmux #(
    parameter int unsigned W = 16,
    parameter int unsigned C = 3
) (
    input  logic [C-1:0]   hold,
    input  logic [C*W-1:0] res_flat,
    output logic           out_valid,
    output logic [W-1:0]   out_data
);
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        for (int i = 0; i < C; i++) begin
            if (hold[i]) begin
                out_valid = 1'b1;
                out_data  = out_data | res_flat[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/rrmc_unit.sv
module rrmc_unit #(
    parameter int unsigned W      = 16,
    parameter int unsigned T      = 4,
    parameter int unsigned T_NEXT = 3,
    parameter int unsigned R      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         err
);
    import rrmc_pkg::*;

    localparam int unsigned C = rrmc_copies(T, T_NEXT, R);

    if (R < 1) begin : g_bad_r
        $error("restart period must be at least one cycle");
    end
    if (T < 1 || T_NEXT < 1) begin : g_bad_t
        $error("compute and hold times must be at least one cycle");
    end
    if (T_NEXT > R) begin : g_bad_hold
        $error("hold windows of consecutive copies would overlap");
    end

    logic [C-1:0]   start_vec;
    logic [C-1:0]   hold_vec;
    logic [C*W-1:0] res_flat;

    rrmc_issue #(.C(C), .R(R)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .start    (start_vec),
        .err      (err)
    );

    for (genvar i = 0; i < C; i++) begin : g_copy
        rrmc_copy #(.W(W), .T(T), .T_NEXT(T_NEXT)) u_copy (
            .clk   (clk),
            .rst   (rst),
            .start (start_vec[i]),
            .op_a  (in_a),
            .op_b  (in_b),
            .hold  (hold_vec[i]),
            .res   (res_flat[i*W +: W])
        );
    end

    rrmc_outmux #(.W(W), .C(C)) u_outmux (
        .hold      (hold_vec),
        .res_flat  (res_flat),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/rrmc_unit_chk.sv
module rrmc_unit_chk #(
    parameter int unsigned W = 16,
    parameter int unsigned C = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         err,
    input logic [C-1:0] hold_vec
);
    // R1: reset leaves the outputs idle
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !err && out_data == '0));

    // R6: the error flag never drops without reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5: the error flag only rises after a strobe
    p_err_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(in_valid));

    // R8: never more than one copy in its hold window
    p_one_owner_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold_vec));

    // R8: idle output reads zero
    p_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    // R3: data steady while the same copy keeps the window
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && hold_vec == $past(hold_vec))
            |-> $stable(out_data));

endmodule

bind rrmc_unit rrmc_unit_chk #(.W(W), .C(C)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .err       (err),
    .hold_vec  (hold_vec)
);

// File: tb/tb_rrmc_unit.sv
module tb_rrmc_unit;
    localparam int unsigned W  = 16;
    localparam int unsigned T  = 4;
    localparam int unsigned TN = 3;
    localparam int unsigned R  = 3;
    localparam int unsigned Q  = T + TN;

    // operand pairs {a, b}
    localparam logic [31:0] VEC [8] = '{
        32'h0001_0002, 32'h1234_4321, 32'hFFFF_0001, 32'h8000_8000,
        32'h00FF_0F00, 32'hAAAA_5555, 32'h7FFF_0001, 32'h0000_0000
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         err;

    int     cyc = 0;
    int     n_checks = 0;
    int     n_errors = 0;
    bit     mon_en = 1'b0;
    string  cur_req = "R1";
    int     it_edge [64];
    logic [W-1:0] it_sum [64];
    int     n_items = 0;

    rrmc_unit #(.W(W), .T(T), .T_NEXT(TN), .R(R)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data),
        .err       (err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // cycle-exact model of the output windows
    always @(negedge clk) begin
        if (mon_en) begin
            logic         ev;
            logic [W-1:0] ed;
            ev = 1'b0;
            ed = '0;
            for (int i = 0; i < n_items; i++) begin
                if (cyc >= it_edge[i] + int'(T) && cyc < it_edge[i] + int'(Q)) begin
                    ev = 1'b1;
                    ed = it_sum[i];
                end
            end
            chk(cur_req, "out_valid", 32'(out_valid), 32'(ev));
            chk(cur_req, "out_data", 32'(out_data), 32'(ed));
        end
    end

    // called at a falling edge; the strobe is taken at the next rising edge
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit acc);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        if (acc) begin
            it_edge[n_items] = cyc + 1;
            it_sum[n_items]  = a + b;
            n_items++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk);
        mon_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        n_items = 0;
        @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: state after reset
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "out_data", 32'(out_data), 32'd0);
        chk("R1", "err", 32'(err), 32'd0);
        mon_en = 1'b1;

        // R2 R3 R4 R8: back-to-back table at the exact restart period
        cur_req = "R2 R3 R4 R8";
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][31:16], VEC[i][15:0], 1'b1);
            idle(R - 1);
        end
        idle(Q + 2);

        // R7: late strobes are accepted without error
        cur_req = "R7";
        send(16'h0102, 16'h0304, 1'b1);
        idle(R + 1);
        send(16'h1000, 16'h2000, 1'b1);
        idle(Q + 2);
        chk("R7", "err", 32'(err), 32'd0);

        // R5: strobe one edge after an accepted one is dropped
        cur_req = "R5";
        send(16'h0011, 16'h0022, 1'b1);
        send(16'hBEEF, 16'h1111, 1'b0);
        chk("R5", "err", 32'(err), 32'd1);
        idle(R - 2);
        send(16'h0300, 16'h0004, 1'b1);
        idle(R - 1);
        send(16'h0050, 16'h0006, 1'b1);
        idle(Q + 2);
        // R6: flag stays set
        chk("R6", "err", 32'(err), 32'd1);

        // R9: reset with two copies in flight
        send(16'h4000, 16'h0001, 1'b1);
        idle(R - 1);
        send(16'h5000, 16'h0002, 1'b1);
        cur_req = "R9";
        do_reset();
        chk("R1", "err after reset", 32'(err), 32'd0);
        idle(Q + R);

        // R10: strobe right after reset, close to pre-reset strobes
        send(16'h4000, 16'h0001, 1'b1);
        idle(R - 1);
        send(16'h5000, 16'h0002, 1'b1);
        do_reset();
        cur_req = "R10";
        send(16'h0600, 16'h0007, 1'b1);
        idle(R - 1);
        send(16'h0800, 16'h0009, 1'b1);
        idle(Q + 2);
        chk("R10", "err", 32'(err), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule